// File: doc/BRIEF.md
# Stacked-Die Test Port Controller

This block sits beside the standard TAP controller of one die in a vertical die stack. It owns a secondary test port that reaches the die directly above: a forwarded test clock, a forwarded mode select, a serial output to the next die and a serial input returning from it. A persistent mode bit, UP or DOWN, decides whether that port joins the scan path. In UP, the die's own selected register feeds the next die and the data that comes back is appended to the primary TDO stream. In DOWN, the next die is cut off and the primary TDO carries only this die's own register.

The mode bit changes only when the instruction register is updated. One instruction code raises it. A second code lowers it. Either BYPASS encoding also lowers it, so a tester can collapse any stack by shifting ones through the IR and passing Update-IR. Passing through Test-Logic-Reset does not lower it. Both serial outputs are retimed on the falling test-clock edge. The data returning from the next die is first registered on the rising edge, which eases die-to-die timing. The forwarded clock can optionally be gated by the mode bit through a latch-based, glitch-free gate.

Top module: `stack_port_ctrl`

## Requirements
- R1: A synchronous reset (power-on or TRST) sampled on a rising TCK edge forces DOWN mode. A reset sampled on a falling edge drives ptdo and stdo to 1.
- R2: A rising edge with upd_ir=1 and ir_new equal to the raise code (default 8'b00100011) enters UP mode on that edge.
- R3: A rising edge with upd_ir=1 and ir_new equal to the lower code (default 8'b00100111) enters DOWN mode on that edge.
- R4: A rising edge with upd_ir=1 and ir_new equal to all ones or all zeros (BYPASS) enters DOWN mode.
- R5: The mode holds whenever upd_ir=0, including a run of TMS=1 that takes the TAP to Test-Logic-Reset. It also holds at Update-IR of any code not named in R2 to R4.
- R6: stms follows tms while UP. In DOWN it is held at the parking level (default 1).
- R7: At each falling TCK edge, stdo is loaded with own_so while UP and with 1 while DOWN.
- R8: At each falling TCK edge, ptdo is loaded with own_so while DOWN. While UP it is loaded with stdi as registered on the preceding rising edge (one stage by default).
- R9: With gating enabled, stck is low throughout any high phase of TCK that follows a low phase spent in DOWN. Otherwise it copies TCK. The gate enable changes only while TCK is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset (POR or TRST) |
| tms | input | 1 | Primary mode select |
| upd_ir | input | 1 | TAP is in Update-IR this cycle |
| ir_new | input | IR_W | Instruction becoming current at Update-IR |
| own_so | input | 1 | Serial output of this die's selected register |
| stdi | input | 1 | Serial data returning from the next die |
| ptdo | output | 1 | Primary serial output, falling-edge timed |
| stdo | output | 1 | Serial output to the next die, falling-edge timed |
| stms | output | 1 | Mode select forwarded to the next die |
| stck | output | 1 | Test clock forwarded to the next die |
| stack_up | output | 1 | Current mode, 1 = UP |

## Verification
A wrong mode bit appears at three ports at once. stms shows it at once, because it follows tms or parks within the same cycle. stdo and ptdo show it at the next falling edge, where they pick the wrong source. stck shows it in the following high phase. A broken rising-edge stage on the return path shifts the appended stream by one bit. This is visible on ptdo in the first UP cycle whose stdi differs from its neighbour. A wrong falling-edge source or reset value differs from the model at the first sample after the next falling edge.

// File: rtl/stack_tap_pkg.sv
package stack_tap_pkg;

  typedef enum logic {
    MODE_DOWN = 1'b0,
    MODE_UP   = 1'b1
  } stack_mode_e;

  typedef enum logic [1:0] {
    ACT_KEEP  = 2'd0,
    ACT_RAISE = 2'd1,
    ACT_LOWER = 2'd2
  } mode_act_e;

endpackage

// File: rtl/stack_mode_reg.sv
module stack_mode_reg
  import stack_tap_pkg::*;
#(
  parameter int            IR_W     = 8,
  parameter logic [IR_W-1:0] RAISE_OP = 8'b0010_0011,
  parameter logic [IR_W-1:0] LOWER_OP = 8'b0010_0111
) (
  input  logic            tck,
  input  logic            rst,
  input  logic            upd_ir,
  input  logic [IR_W-1:0] ir_new,
  output stack_mode_e     mode
);

  localparam logic [IR_W-1:0] BYP_ONES  = {IR_W{1'b1}};
  localparam logic [IR_W-1:0] BYP_ZEROS = {IR_W{1'b0}};

  mode_act_e act;

  // classify the instruction that is becoming current
  always_comb begin
    act = ACT_KEEP;
    if (upd_ir) begin
      if (ir_new == RAISE_OP)
        act = ACT_RAISE;
      else if (ir_new == LOWER_OP || ir_new == BYP_ONES || ir_new == BYP_ZEROS)
        act = ACT_LOWER;
    end
  end

  always_ff @(posedge tck) begin
    if (rst)
      mode <= MODE_DOWN;
    else begin
      case (act)
        ACT_RAISE: mode <= MODE_UP;
        ACT_LOWER: mode <= MODE_DOWN;
        default:   mode <= mode;
      endcase
    end
  end

endmodule

// File: rtl/stack_ret_pipe.sv
module stack_ret_pipe #(
  parameter int STAGES = 1
) (
  input  logic tck,
  input  logic rst,
  input  logic din,
  output logic dout
);

  localparam int N = (STAGES < 1) ? 1 : STAGES;

  logic [N-1:0] stg;

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge tck) begin
          if (rst) stg[0] <= 1'b0;
          else     stg[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge tck) begin
          if (rst) stg[i] <= 1'b0;
          else     stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign dout = stg[N-1];

endmodule

// File: rtl/stack_fall_latch.sv
module stack_fall_latch #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic tck,
  input  logic rst,
  input  logic d,
  output logic q
);

  always_ff @(negedge tck) begin
    if (rst) q <= RST_VAL;
    else     q <= d;
  end

endmodule

// File: rtl/stack_clk_gate.sv
module stack_clk_gate #(
  parameter bit GATED = 1'b1
) (
  input  logic tck,
  input  logic en,
  output logic gclk
);

  generate
    if (GATED) begin : g_gate
      logic en_lat;
      // transparent only while the clock is low
      always_latch begin
        if (!tck) en_lat = en;
      end
      assign gclk = tck & en_lat;
    end else begin : g_pass
      logic unused_en;
      assign unused_en = en;
      assign gclk = tck;
    end
  endgenerate

endmodule

// File: rtl/stack_port_ctrl.sv
module stack_port_ctrl
  import stack_tap_pkg::*;
#(
  parameter int              IR_W        = 8,
  parameter logic [IR_W-1:0] RAISE_OP    = 8'b0010_0011,
  parameter logic [IR_W-1:0] LOWER_OP    = 8'b0010_0111,
  parameter int              RET_STAGES  = 1,
  parameter bit              GATE_TCK    = 1'b1,
  parameter logic            PARK_TMS    = 1'b1
) (
  input  logic            tck,
  input  logic            rst,
  input  logic            tms,
  input  logic            upd_ir,
  input  logic [IR_W-1:0] ir_new,
  input  logic            own_so,
  input  logic            stdi,
  output logic            ptdo,
  output logic            stdo,
  output logic            stms,
  output logic            stck,
  output logic            stack_up
);

  stack_mode_e mode;
  logic        ret_q;
  logic        pri_d;
  logic        sec_d;
  logic        is_up;

  stack_mode_reg #(
    .IR_W     (IR_W),
    .RAISE_OP (RAISE_OP),
    .LOWER_OP (LOWER_OP)
  ) u_mode (
    .tck    (tck),
    .rst    (rst),
    .upd_ir (upd_ir),
    .ir_new (ir_new),
    .mode   (mode)
  );

  assign is_up = (mode == MODE_UP);

  stack_ret_pipe #(
    .STAGES (RET_STAGES)
  ) u_ret (
    .tck  (tck),
    .rst  (rst),
    .din  (stdi),
    .dout (ret_q)
  );

  // path select: the upper die is appended after this die's register
  assign pri_d = is_up ? ret_q  : own_so;
  assign sec_d = is_up ? own_so : 1'b1;

  stack_fall_latch #(.RST_VAL(1'b1)) u_pri_out (
    .tck (tck),
    .rst (rst),
    .d   (pri_d),
    .q   (ptdo)
  );

  stack_fall_latch #(.RST_VAL(1'b1)) u_sec_out (
    .tck (tck),
    .rst (rst),
    .d   (sec_d),
    .q   (stdo)
  );

  assign stms = is_up ? tms : PARK_TMS;

  stack_clk_gate #(.GATED(GATE_TCK)) u_cg (
    .tck  (tck),
    .en   (is_up),
    .gclk (stck)
  );

  assign stack_up = is_up;

endmodule

// File: rtl/stack_port_ctrl_chk.sv
module stack_port_ctrl_chk #(
  parameter int              IR_W     = 8,
  parameter logic [IR_W-1:0] RAISE_OP = 8'b0010_0011,
  parameter logic [IR_W-1:0] LOWER_OP = 8'b0010_0111,
  parameter logic            PARK_TMS = 1'b1
) (
  input logic            tck,
  input logic            rst,
  input logic            upd_ir,
  input logic [IR_W-1:0] ir_new,
  input logic            stdo,
  input logic            stms,
  input logic            stack_up
);

  AST_RAISE_ENTERS_UP: assert property (@(posedge tck) disable iff (rst)
    (upd_ir && ir_new == RAISE_OP) |=> stack_up);  // R2

  AST_LOWER_ENTERS_DOWN: assert property (@(posedge tck) disable iff (rst)
    (upd_ir && ir_new == LOWER_OP) |=> !stack_up);  // R3

  AST_BYPASS_COLLAPSES: assert property (@(posedge tck) disable iff (rst)
    (upd_ir && (&ir_new || !(|ir_new))) |=> !stack_up);  // R4

  AST_MODE_HOLDS: assert property (@(posedge tck) disable iff (rst)
    !upd_ir |=> $stable(stack_up));  // R5

  AST_TMS_PARKED: assert property (@(posedge tck) disable iff (rst)
    !stack_up |-> (stms == PARK_TMS));  // R6

  AST_STDO_IDLE_HIGH: assert property (@(posedge tck) disable iff (rst)
    (!stack_up && !$past(stack_up)) |-> stdo);  // R7

endmodule

bind stack_port_ctrl stack_port_ctrl_chk #(
  .IR_W     (IR_W),
  .RAISE_OP (RAISE_OP),
  .LOWER_OP (LOWER_OP),
  .PARK_TMS (PARK_TMS)
) u_chk (
  .tck      (tck),
  .rst      (rst),
  .upd_ir   (upd_ir),
  .ir_new   (ir_new),
  .stdo     (stdo),
  .stms     (stms),
  .stack_up (stack_up)
);

// File: tb/stack_port_ctrl_test.sv
module stack_port_ctrl_test;

  localparam logic [7:0] OP_UP  = 8'b0010_0011;
  localparam logic [7:0] OP_DN  = 8'b0010_0111;
  localparam logic [7:0] OP_EXT = 8'b0000_1111;
  localparam logic       PARK   = 1'b1;

  logic       tck = 1'b0;
  logic       rst = 1'b1;
  logic       tms = 1'b0;
  logic       upd_ir = 1'b0;
  logic [7:0] ir_new = 8'h00;
  logic       own_so = 1'b0;
  logic       stdi = 1'b0;
  logic       ptdo, stdo, stms, stck, stack_up;

  stack_port_ctrl uut (
    .tck(tck), .rst(rst), .tms(tms), .upd_ir(upd_ir), .ir_new(ir_new),
    .own_so(own_so), .stdi(stdi), .ptdo(ptdo), .stdo(stdo), .stms(stms),
    .stck(stck), .stack_up(stack_up)
  );

  always #5 tck = ~tck;

  int vectors = 0;
  int misses  = 0;

  // behavioural reference state
  bit m_up = 1'b0;
  bit up_prev = 1'b0;
  bit ret_q[$];

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(input bit r, input bit u, input logic [7:0] c,
                      input bit t, input bit sd, input bit so, input string req);
    bit e_ptdo, e_stdo;
    @(posedge tck);
    up_prev = m_up;
    if (rst) m_up = 1'b0;
    else if (upd_ir) begin
      if (ir_new == OP_UP) m_up = 1'b1;
      else if (ir_new == OP_DN || ir_new == 8'hFF || ir_new == 8'h00) m_up = 1'b0;
    end
    ret_q.push_back(rst ? 1'b0 : stdi);
    if (ret_q.size() > 1) void'(ret_q.pop_front());
    #1;
    rst = r; upd_ir = u; ir_new = c; tms = t; stdi = sd; own_so = so;
    #2;
    chk("R9", "stck high phase", stck, up_prev);
    #5;
    if (rst) begin
      e_ptdo = 1'b1; e_stdo = 1'b1;
    end else begin
      e_ptdo = m_up ? ret_q[0] : so;
      e_stdo = m_up ? so : 1'b1;
    end
    chk({req, "/R8"}, "ptdo", ptdo, e_ptdo);
    chk({req, "/R7"}, "stdo", stdo, e_stdo);
    chk({req, "/R6"}, "stms", stms, m_up ? t : PARK);
    chk(req, "stack_up", stack_up, m_up);
  endtask

  task automatic idle_run(input int n, input bit t_level, input string req);
    for (int i = 0; i < n; i++)
      step(1'b0, 1'b0, 8'h5A, t_level ? 1'b1 : 1'($urandom),
           1'($urandom), 1'($urandom), req);
  endtask

  task automatic update(input logic [7:0] c, input string req);
    step(1'b0, 1'b1, c, 1'b0, 1'($urandom), 1'($urandom), req);
  endtask

  initial begin
    repeat (3) @(posedge tck);
    // R1: reset held, outputs at idle values
    step(1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, "R1");
    step(1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, "R1");
    step(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, "R1");
    // DOWN traffic: own register only (R8), stdo high (R7)
    idle_run(8, 1'b0, "R8");
    // unrelated instruction keeps DOWN (R5)
    update(OP_EXT, "R5");
    idle_run(3, 1'b0, "R5");
    // raise (R2) and run UP traffic
    update(OP_UP, "R2");
    idle_run(12, 1'b0, "R2");
    // Test-Logic-Reset walk: mode persists (R5)
    idle_run(6, 1'b1, "R5");
    update(OP_EXT, "R5");
    idle_run(4, 1'b0, "R5");
    // all-ones BYPASS collapses (R4)
    update(8'hFF, "R4");
    idle_run(4, 1'b0, "R4");
    update(OP_UP, "R2");
    idle_run(3, 1'b0, "R2");
    // all-zeros BYPASS collapses (R4)
    update(8'h00, "R4");
    idle_run(4, 1'b0, "R4");
    update(OP_UP, "R2");
    idle_run(3, 1'b0, "R2");
    // explicit lower code (R3)
    update(OP_DN, "R3");
    idle_run(4, 1'b0, "R3");
    // reset while UP returns to DOWN (R1)
    update(OP_UP, "R2");
    idle_run(2, 1'b0, "R2");
    step(1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, "R1");
    step(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, "R1");
    idle_run(4, 1'b0, "R1");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #200000;
    misses++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule